// File: doc/BRIEF.md
# Deficit Idle Gap Controller

This block sits beside the transmit datapath of a wide Ethernet MAC that moves eight byte lanes per clock. On every end of frame it reports how many idle bytes must follow before the next frame may begin. Each frame has to start on lane 0 of a word, so the exact gap cannot always be met. A small deficit counter records the rounding error: the gap is sometimes a few bytes short of nominal and sometimes a few bytes long, and over time the average is held at the 12-byte (96 bit time) minimum.

A second function recovers the bandwidth that the PHY later spends on alignment markers. A byte counter accumulates the transmitted byte count and raises a deletion request each time it reaches a programmed period. A typical setting is one idle removed per 16384 bytes. Requests wait in a small pending counter. Each one shortens the nominal gap of the next end of frame by one byte, and a deletion never lands in the middle of a frame. A separate enable switches the deletion function on and off.

Top module: `ipg_deficit_ctrl`

## Requirements
- R1: After reset `idle_valid` is 0, and the deficit count and the pending deletion count are both 0. With no deletion, an end of frame on lane 7 therefore yields 8 idle bytes.
- R2: `idle_valid` is high for exactly the one cycle that follows each cycle in which `eof_valid` is high, and `idle_cnt` is valid in that cycle.
- R3: `eof_lane` gives the lane of the last frame byte, where lane 0 is the first byte of a word. In every valid result, `eof_lane + 1 + idle_cnt` is a multiple of 8, so the next frame starts on lane 0.
- R4: Let the target position be `p = eof_lane + 1 + N`, where N is 12, or 11 when a deletion is applied, and let `s = p mod 8`. If `deficit + s <= 7`, the gap rounds down and the deficit grows by s. Otherwise the gap rounds up to the next boundary and the deficit shrinks by `8 - s`.
- R5: Every reported gap lies between N-7 and N+7 bytes.
- R6: Across any run of frames, the sum of the nominal gaps N minus the sum of the reported gaps always stays between 0 and 7.
- R7: While `del_en` is 1, the byte counter adds `tx_bytes` each cycle. When the sum reaches `del_period`, the counter keeps the remainder and one deletion request is raised. `del_period` must be at least 8.
- R8: A pending deletion is applied only at an end of frame. It lowers N to 11 for that gap and removes one from the pending count.
- R9: Requests accumulate in a pending counter that saturates at 7. A request raised in the same cycle as an end of frame is not used for that gap; it is kept for a later gap.
- R10: While `del_en` is 0, the pending count is cleared, the byte counter holds its value, and no gap is shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_valid | input | 1 | Last word of a frame is on the datapath this cycle |
| eof_lane | input | 3 | Lane of the last frame byte in that word |
| tx_bytes | input | 4 | Bytes transmitted this cycle (0 to 8) |
| del_en | input | 1 | Idle deletion enable |
| del_period | input | 16 | Bytes between idle deletions |
| idle_valid | output | 1 | `idle_cnt` holds a new gap length |
| idle_cnt | output | 5 | Idle bytes to place after the frame, counted from its last byte |

## Verification
Two events can fall in the same cycle: the byte counter crossing its period, and an end of frame that consumes a pending deletion. Small periods and dense frame endings make this happen repeatedly. The bench counts each coincidence and requires at least one. A behavioural model in the bench applies the old pending count to the gap and keeps the new request for later. The result is judged by comparing the gap lengths in every later cycle, which shows whether the request was applied too early, lost, or counted twice.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
   localparam int unsigned STD_GAP_BYTES  = 12;
   localparam int unsigned STD_DEL_PERIOD = 16384;
endpackage

// File: rtl/ipg_del_timer.sv
module ipg_del_timer #(
   parameter int unsigned PERIOD_W = 16,
   parameter int unsigned TX_W     = 4,
   parameter int unsigned PEND_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                del_en,
   input  logic [PERIOD_W-1:0] del_period,
   input  logic [TX_W-1:0]     tx_bytes,
   input  logic                take,
   output logic                pend_any
);
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [PERIOD_W-1:0] byte_cnt;
   logic [PERIOD_W:0]   sum;
   logic                hit;
   logic                req;
   logic [PEND_W-1:0]   pend_q;

   assign sum = {1'b0, byte_cnt} + (PERIOD_W+1)'(tx_bytes);
   assign hit = sum >= {1'b0, del_period};
   assign req = del_en & hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_cnt <= '0;
      end else if (del_en) begin
         if (hit) byte_cnt <= PERIOD_W'(sum - {1'b0, del_period});
         else     byte_cnt <= sum[PERIOD_W-1:0];
      end
   end

   generate
      if (PEND_W == 1) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n || !del_en) pend_q <= '0;
            else if (req)          pend_q <= 1'b1;
            else if (take)         pend_q <= 1'b0;
         end
      end else begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n || !del_en) begin
               pend_q <= '0;
            end else if (req && !take) begin
               if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
            end else if (take && !req) begin
               pend_q <= pend_q - 1'b1;
            end
         end
      end
   endgenerate

   assign pend_any = pend_q != '0;

   // R10
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !del_en |=> pend_q == '0);
   // R10
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !del_en |=> byte_cnt == $past(byte_cnt));
   // R9
   pend_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !take && pend_q != PEND_MAX) |=> pend_q == $past(pend_q) + PEND_W'(1));
   // R8
   take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend_any);
endmodule

// File: rtl/ipg_dic_round.sv
module ipg_dic_round #(
   parameter int unsigned LANES     = 8,
   parameter int unsigned GAP_BYTES = 12,
   parameter int unsigned LANE_W    = 3,
   parameter int unsigned CNT_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eof_valid,
   input  logic [LANE_W-1:0] eof_lane,
   input  logic              del_now,
   output logic              idle_valid,
   output logic [CNT_W-1:0]  idle_cnt
);
   localparam int unsigned POS_W = CNT_W + 1;

   logic [LANE_W-1:0] dic_q;
   logic [POS_W-1:0]  used;
   logic [POS_W-1:0]  pos;
   logic [LANE_W-1:0] shrink;
   logic [POS_W-1:0]  down;
   logic [LANE_W:0]   dsum;
   logic              fits;
   logic [CNT_W-1:0]  nxt_idle;
   logic [LANE_W-1:0] nxt_dic;

   always_comb begin
      used     = POS_W'(eof_lane) + POS_W'(1);
      pos      = used + POS_W'(GAP_BYTES) - POS_W'(del_now);
      shrink   = pos[LANE_W-1:0];
      down     = {pos[POS_W-1:LANE_W], {LANE_W{1'b0}}};
      dsum     = {1'b0, dic_q} + {1'b0, shrink};
      fits     = dsum <= (LANE_W+1)'(LANES - 1);
      if (fits) begin
         nxt_idle = CNT_W'(down - used);
         nxt_dic  = dsum[LANE_W-1:0];
      end else begin
         nxt_idle = CNT_W'(down + POS_W'(LANES) - used);
         nxt_dic  = LANE_W'(dsum - (LANE_W+1)'(LANES));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_valid <= 1'b0;
         idle_cnt   <= '0;
         dic_q      <= '0;
      end else begin
         idle_valid <= eof_valid;
         if (eof_valid) begin
            idle_cnt <= nxt_idle;
            dic_q    <= nxt_dic;
         end
      end
   end

   // R5
   gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_valid |-> (idle_cnt >= CNT_W'(GAP_BYTES - LANES)) &&
                     (idle_cnt <= CNT_W'(GAP_BYTES + LANES - 1)));
   // R4
   dic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_valid |=> $stable(dic_q));
endmodule

// File: rtl/ipg_deficit_ctrl.sv
module ipg_deficit_ctrl #(
   parameter int unsigned LANES     = 8,
   parameter int unsigned GAP_BYTES = ipg_pkg::STD_GAP_BYTES,
   parameter int unsigned PERIOD_W  = 16,
   parameter int unsigned PEND_W    = 3,
   localparam int unsigned LANE_W   = $clog2(LANES),
   localparam int unsigned TX_W     = $clog2(LANES + 1),
   localparam int unsigned CNT_W    = $clog2(GAP_BYTES + LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eof_valid,
   input  logic [LANE_W-1:0]   eof_lane,
   input  logic [TX_W-1:0]     tx_bytes,
   input  logic                del_en,
   input  logic [PERIOD_W-1:0] del_period,
   output logic                idle_valid,
   output logic [CNT_W-1:0]    idle_cnt
);
   generate
      if ((1 << LANE_W) != LANES || LANES < 2) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (GAP_BYTES < LANES) begin : g_bad_gap
         $error("GAP_BYTES must be at least LANES");
      end
      if (PEND_W < 1 || PERIOD_W < TX_W) begin : g_bad_width
         $error("PEND_W or PERIOD_W too small");
      end
   endgenerate

   logic pend_any;
   logic take;

   assign take = eof_valid & del_en & pend_any;

   ipg_del_timer #(
      .PERIOD_W (PERIOD_W),
      .TX_W     (TX_W),
      .PEND_W   (PEND_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .del_en     (del_en),
      .del_period (del_period),
      .tx_bytes   (tx_bytes),
      .take       (take),
      .pend_any   (pend_any)
   );

   ipg_dic_round #(
      .LANES     (LANES),
      .GAP_BYTES (GAP_BYTES),
      .LANE_W    (LANE_W),
      .CNT_W     (CNT_W)
   ) u_round (
      .clk        (clk),
      .rst_n      (rst_n),
      .eof_valid  (eof_valid),
      .eof_lane   (eof_lane),
      .del_now    (take),
      .idle_valid (idle_valid),
      .idle_cnt   (idle_cnt)
   );

   // R2
   pulse_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eof_valid |=> idle_valid);
   // R2
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_valid |-> $past(eof_valid));
   // R3
   lane_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_valid |-> ((CNT_W+1)'($past(eof_lane)) + (CNT_W+1)'(1)
                      + (CNT_W+1)'(idle_cnt)) % (CNT_W+1)'(LANES) == '0);
endmodule

// File: tb/ipg_deficit_ctrl_bench.sv
`timescale 1ns/1ps
module ipg_deficit_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eof_valid = 1'b0;
   logic [2:0]  eof_lane = '0;
   logic [3:0]  tx_bytes = '0;
   logic        del_en = 1'b0;
   logic [15:0] del_period = 16'd16384;
   logic        idle_valid;
   logic [4:0]  idle_cnt;

   always #2.5 clk = ~clk;

   ipg_deficit_ctrl u_ipg_deficit_ctrl (
      .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .eof_lane(eof_lane),
      .tx_bytes(tx_bytes), .del_en(del_en), .del_period(del_period),
      .idle_valid(idle_valid), .idle_cnt(idle_cnt)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;
   int coincide = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference model
   int m_dic = 0, m_pend = 0, m_bc = 0;
   bit m_valid = 0;
   int m_cnt = 0, m_lane = 0;
   int sum_nom = 0, sum_dut = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_dic = 0; m_pend = 0; m_bc = 0; m_valid = 0;
      end else begin
         bit apply, req;
         int nom, p, s;
         apply = eof_valid && del_en && (m_pend > 0);
         req = 0;
         m_valid = eof_valid;
         if (eof_valid) begin
            nom = apply ? 11 : 12;
            p = int'(eof_lane) + 1 + nom;
            s = p % 8;
            if (m_dic + s <= 7) begin
               m_cnt = p - s - (int'(eof_lane) + 1);
               m_dic = m_dic + s;
            end else begin
               m_cnt = p - s + 8 - (int'(eof_lane) + 1);
               m_dic = m_dic - (8 - s);
            end
            m_lane = int'(eof_lane);
            sum_nom += nom;
         end
         if (del_en) begin
            if (m_bc + int'(tx_bytes) >= int'(del_period)) begin
               m_bc = m_bc + int'(tx_bytes) - int'(del_period);
               req = 1;
            end else begin
               m_bc = m_bc + int'(tx_bytes);
            end
            m_pend = m_pend - (apply ? 1 : 0) + (req ? 1 : 0);
            if (m_pend > 7) m_pend = 7;
            if (req && eof_valid) coincide++;
         end else begin
            m_pend = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(idle_valid == m_valid, {tag, " R2 valid"}, int'(idle_valid), int'(m_valid));
         if (idle_valid && m_valid) begin
            chk(int'(idle_cnt) == m_cnt, {tag, " R4 gap"}, int'(idle_cnt), m_cnt);
            chk((m_lane + 1 + int'(idle_cnt)) % 8 == 0, "R3 boundary",
                (m_lane + 1 + int'(idle_cnt)) % 8, 0);
            sum_dut += int'(idle_cnt);
            chk(sum_nom - sum_dut >= 0 && sum_nom - sum_dut <= 7, "R6 average",
                sum_nom - sum_dut, 0);
            chk(int'(idle_cnt) >= 4 && int'(idle_cnt) <= 19, "R5 range", int'(idle_cnt), 12);
         end
      end
   end

   task automatic step(input bit eof, input int lane, input int tx);
      @(negedge clk);
      eof_valid = eof;
      eof_lane = 3'(lane);
      tx_bytes = 4'(tx);
   endtask

   task automatic frame(input int words, input int lane, input int gapcyc);
      for (int i = 0; i < words; i++) step(1'b0, 0, 8);
      step(1'b1, lane, lane + 1);
      for (int i = 0; i < gapcyc; i++) step(1'b0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(idle_valid == 1'b0, "R1 reset valid", int'(idle_valid), 0);
      rst_n = 1'b1;
      // R1: first gap after reset, lane 7, zero deficit -> 8 idles
      tag = "R1";
      step(1'b1, 7, 8);
      step(1'b0, 0, 0);
      @(negedge clk);
      chk(int'(idle_cnt) == 8, "R1 first gap", int'(idle_cnt), 8);
      // R3/R4: every end lane, deletion off
      tag = "R4";
      for (int l = 0; l < 8; l++) frame(2, l, 2);
      for (int l = 7; l >= 0; l--) frame(1, l, 1);
      // R7/R8: deletion on with short period
      tag = "R8";
      del_period = 16'd40;
      del_en = 1'b1;
      for (int k = 0; k < 12; k++) frame(4, k % 8, 2);
      // R9: many requests during a long frame, saturation
      tag = "R9";
      del_period = 16'd16;
      frame(24, 3, 1);
      del_period = 16'd60000;
      for (int k = 0; k < 10; k++) frame(1, (k * 3) % 8, 1);
      // R11-style coincidence: dense endings, small period
      tag = "R9 coincide";
      del_period = 16'd9;
      for (int k = 0; k < 40; k++) step(1'b1, k % 8, 8);
      step(1'b0, 0, 0);
      // R10: disable clears pending and freezes counter
      tag = "R10";
      del_period = 16'd16;
      frame(10, 2, 1);
      del_en = 1'b0;
      for (int k = 0; k < 6; k++) frame(3, (k + 5) % 8, 1);
      del_en = 1'b1;
      for (int k = 0; k < 6; k++) frame(2, k, 1);
      // R7 mixed random traffic
      tag = "R7 random";
      for (int k = 0; k < 4000; k++) begin
         if (k % 500 == 0) del_period = 16'($urandom_range(8, 64));
         if (k % 700 == 350) del_en = ~del_en;
         step(($urandom_range(0, 3) == 0), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 8)));
      end
      step(1'b0, 0, 0);
      step(1'b0, 0, 0);
      chk(coincide > 0, "R9 same-cycle request", coincide, 1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 150000 && !done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule